// File: doc/BRIEF.md
# Synthesizer Control Register Slave over I2C

This block is a two-wire serial slave that keeps the control word of a frequency synthesizer: a 15-bit main divider value, a 3-bit operating mode, a 3-bit reference ratio select and a 2-bit pump current select. A host addresses it with a 7-bit address. The upper five bits of that address are fixed and the lower two come from strap inputs, so four of these blocks can share one bus.

In a write transfer the slave accepts any number of data bytes until STOP. It needs no register pointer. The most significant bit of each classified byte says what the byte is. A cleared MSB opens a divider pair (high part, then low part). A set MSB opens a control pair (mode and ratio, then pump current). Each divider update is applied as one word, so the synthesizer never sees half of a new value. In a read transfer the slave returns a status byte that carries a power-up flag and the current lock indication. The power-up flag is cleared once the host ends a read.

SCL and SDA are sampled with a system clock that is much faster than the bus clock. SDA is open-drain and is modelled as an output enable that pulls the line low.

Top module: `tuner_i2c_regs`

## Requirements
- R1: The slave acknowledges only the address {5'b11000, addr_sel_i[1], addr_sel_i[0]} followed by the R/W bit. For any other address it drives no ACK, and the data bytes that follow leave every register output unchanged.
- R2: In a write, the first data byte after the address is classified by bit 7. A 0 means a divider high byte, whose bits 6:0 become div_o[14:8]. A 1 means a control byte: mode_o takes bits 6:4 and ref_o takes bits 3:1.
- R3: Data bytes auto-increment. A divider high byte is followed by the divider low byte (div_o[7:0]), and a control byte is followed by the current byte (cp_o = bits 7:6). The byte after either pair is classified again by its bit 7.
- R4: div_o changes as one word on the 8th SCL rise of the low byte. If only a high byte was sent, div_o[14:8] takes it at STOP and div_o[7:0] keeps its value. Before that commit point div_o does not change.
- R5: mode_o, ref_o and cp_o take their new values on the 8th SCL rise of their byte, without waiting for STOP.
- R6: A read returns the status byte MSB first: bit 7 is the power-up flag, bit 6 is lock_i, and bits 5:0 are 0.
- R7: If the host ACKs a status byte, another status byte follows. After a host NACK the slave keeps SDA released.
- R8: The power-up flag is 1 after reset. It stays 1 through writes and through status bytes the host ACKs. It becomes 0 when a read ends with a host NACK.
- R9: After reset, mode_o = 3'b001, div_o, ref_o and cp_o are 0, and SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Asynchronous reset, active low (power-up / brownout) |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| addr_sel_i | input | 2 | Low two bits of the slave address |
| lock_i | input | 1 | Synthesizer lock indication |
| div_o | output | 15 | Main divider value |
| mode_o | output | 3 | Operating mode field |
| ref_o | output | 3 | Reference ratio select |
| cp_o | output | 2 | Charge pump current select |

## Verification
Two situations are hard to reach from the ports, and both depend on where the host ends a transfer. The first is a high divider byte sent with no low byte, which commits only at STOP. The bench samples div_o after that byte's ACK and again after STOP, so it sees that the value was held back and then merged with the old low half. The second is the clearing of the power-up flag. The bench reads two status bytes, ACKing the first and NACKing the second, and checks that the flag survives the first byte and is 0 in the next read. It also resets the block in the middle of the run, then writes and reads again, to show that writes leave the flag set.

// File: rtl/tcr_pkg.sv
package tcr_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_SACK, ST_WR, ST_RD, ST_MACK
  } bus_st_e;

  typedef enum logic [1:0] {
    NX_CLASS, NX_PD_LO, NX_CUR
  } nxt_e;
endpackage

// File: rtl/tcr_sync.sv
module tcr_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] sh;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sh <= '1;
      else         sh <= {sh[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = sh[STAGES-1];
  end
endmodule

// File: rtl/tcr_bus.sv
module tcr_bus
  import tcr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_s_i,
  input  logic              sda_s_i,
  input  logic [6:0]        dev_addr_i,
  input  logic [BYTE_W-1:0] status_i,
  output logic              sda_oe_o,
  output logic              byte_stb_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              wr_start_o,
  output logic              start_o,
  output logic              stop_o,
  output logic              read_end_o
);
  localparam int CNT_W = $clog2(BYTE_W + 1);

  bus_st_e           st;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] sh;
  logic              scl_q, sda_q, rw, mack, oe;
  logic              scl_rise, scl_fall;

  assign scl_rise = scl_s_i & ~scl_q;
  assign scl_fall = ~scl_s_i & scl_q;
  assign start_o  = scl_s_i & scl_q & sda_q & ~sda_s_i;
  assign stop_o   = scl_s_i & scl_q & ~sda_q & sda_s_i;
  assign sda_oe_o = oe;
  assign byte_o   = sh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st <= ST_IDLE; cnt <= '0; sh <= '0; rw <= 1'b0; mack <= 1'b0; oe <= 1'b0;
      scl_q <= 1'b1; sda_q <= 1'b1;
      byte_stb_o <= 1'b0; wr_start_o <= 1'b0; read_end_o <= 1'b0;
    end else begin
      scl_q <= scl_s_i;
      sda_q <= sda_s_i;
      byte_stb_o <= 1'b0; wr_start_o <= 1'b0; read_end_o <= 1'b0;
      if (start_o) begin
        st <= ST_ADDR; cnt <= '0; oe <= 1'b0;
      end else if (stop_o) begin
        st <= ST_IDLE; oe <= 1'b0;
      end else begin
        unique case (st)
          ST_ADDR: begin
            if (scl_rise) begin
              sh <= {sh[BYTE_W-2:0], sda_s_i}; cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == CNT_W'(BYTE_W)) begin
              if (sh[BYTE_W-1:1] == dev_addr_i) begin
                st <= ST_SACK; oe <= 1'b1; rw <= sh[0]; wr_start_o <= ~sh[0];
              end else st <= ST_IDLE;
            end
          end
          ST_SACK: if (scl_fall) begin
            cnt <= '0;
            if (rw) begin st <= ST_RD; sh <= status_i; oe <= ~status_i[BYTE_W-1]; end
            else    begin st <= ST_WR; oe <= 1'b0; end
          end
          ST_WR: begin
            if (scl_rise) begin
              sh <= {sh[BYTE_W-2:0], sda_s_i}; cnt <= cnt + 1'b1;
              if (cnt == CNT_W'(BYTE_W - 1)) byte_stb_o <= 1'b1;
            end else if (scl_fall && cnt == CNT_W'(BYTE_W)) begin
              st <= ST_SACK; oe <= 1'b1;
            end
          end
          ST_RD: if (scl_fall) begin
            if (cnt == CNT_W'(BYTE_W - 1)) begin
              oe <= 1'b0; st <= ST_MACK;
            end else begin
              sh <= {sh[BYTE_W-2:0], 1'b0}; oe <= ~sh[BYTE_W-2]; cnt <= cnt + 1'b1;
            end
          end
          ST_MACK: begin
            if (scl_rise) mack <= ~sda_s_i;
            else if (scl_fall) begin
              if (mack) begin
                st <= ST_RD; cnt <= '0; sh <= status_i; oe <= ~status_i[BYTE_W-1];
              end else begin
                st <= ST_IDLE; read_end_o <= 1'b1;
              end
            end
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/tcr_regs.sv
module tcr_regs
  import tcr_pkg::*;
#(
  parameter int              DIV_W    = 15,
  parameter int              MODE_W   = 3,
  parameter int              REF_W    = 3,
  parameter int              CP_W     = 2,
  parameter logic [MODE_W-1:0] MODE_RST = 3'b001
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_stb_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              wr_start_i,
  input  logic              stop_i,
  output logic [DIV_W-1:0]  div_o,
  output logic [MODE_W-1:0] mode_o,
  output logic [REF_W-1:0]  ref_o,
  output logic [CP_W-1:0]   cp_o
);
  localparam int HI_W     = DIV_W - BYTE_W;
  localparam int MODE_MSB = BYTE_W - 2;
  localparam int REF_MSB  = MODE_MSB - MODE_W;

  nxt_e            nx;
  logic [HI_W-1:0] hold;
  logic            pend;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nx <= NX_CLASS; hold <= '0; pend <= 1'b0;
      div_o <= '0; mode_o <= MODE_RST; ref_o <= '0; cp_o <= '0;
    end else if (wr_start_i) begin
      nx <= NX_CLASS;
    end else if (byte_stb_i) begin
      unique case (nx)
        NX_CLASS: begin
          if (!byte_i[BYTE_W-1]) begin
            hold <= byte_i[HI_W-1:0]; pend <= 1'b1; nx <= NX_PD_LO;
          end else begin
            mode_o <= byte_i[MODE_MSB -: MODE_W];
            ref_o  <= byte_i[REF_MSB -: REF_W];
            nx     <= NX_CUR;
          end
        end
        NX_PD_LO: begin
          div_o <= {hold, byte_i}; pend <= 1'b0; nx <= NX_CLASS;
        end
        NX_CUR: begin
          cp_o <= byte_i[BYTE_W-1 -: CP_W]; nx <= NX_CLASS;
        end
        default: nx <= NX_CLASS;
      endcase
    end else if (stop_i && pend) begin
      // lone high byte commits at STOP, low half kept
      div_o[DIV_W-1 -: HI_W] <= hold;
      pend <= 1'b0;
    end
  end
endmodule

// File: rtl/tuner_i2c_regs.sv
module tuner_i2c_regs
  import tcr_pkg::*;
#(
  parameter int              DIV_W       = 15,
  parameter int              MODE_W      = 3,
  parameter int              REF_W       = 3,
  parameter int              CP_W        = 2,
  parameter int              SEL_W       = 2,
  parameter logic [4:0]      ADDR_FIXED  = 5'b11000,
  parameter int              SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic [SEL_W-1:0]  addr_sel_i,
  input  logic              lock_i,
  output logic [DIV_W-1:0]  div_o,
  output logic [MODE_W-1:0] mode_o,
  output logic [REF_W-1:0]  ref_o,
  output logic [CP_W-1:0]   cp_o
);
  localparam int PAD_W = BYTE_W - 2;

  logic              scl_s, sda_s, lock_s;
  logic              byte_stb, wr_start, start_evt, stop_evt, read_end, por_q;
  logic [BYTE_W-1:0] rx_byte, status;

  tcr_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni,
    .d_i ({lock_i, sda_i, scl_i}),
    .q_o ({lock_s, sda_s, scl_s})
  );

  assign status = {por_q, lock_s, {PAD_W{1'b0}}};

  tcr_bus u_bus (
    .clk_i, .rst_ni,
    .scl_s_i    (scl_s),
    .sda_s_i    (sda_s),
    .dev_addr_i ({ADDR_FIXED, addr_sel_i}),
    .status_i   (status),
    .sda_oe_o,
    .byte_stb_o (byte_stb),
    .byte_o     (rx_byte),
    .wr_start_o (wr_start),
    .start_o    (start_evt),
    .stop_o     (stop_evt),
    .read_end_o (read_end)
  );

  tcr_regs #(.DIV_W(DIV_W), .MODE_W(MODE_W), .REF_W(REF_W), .CP_W(CP_W)) u_regs (
    .clk_i, .rst_ni,
    .byte_stb_i (byte_stb),
    .byte_i     (rx_byte),
    .wr_start_i (wr_start),
    .stop_i     (stop_evt),
    .div_o, .mode_o, .ref_o, .cp_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       por_q <= 1'b1;
    else if (read_end) por_q <= 1'b0;
  end
endmodule

// File: rtl/tcr_chk.sv
module tcr_chk #(
  parameter int DIV_W  = 15,
  parameter int MODE_W = 3,
  parameter int REF_W  = 3,
  parameter int CP_W   = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              scl_i,
  input logic              sda_oe_o,
  input logic [DIV_W-1:0]  div_o,
  input logic [MODE_W-1:0] mode_o,
  input logic [REF_W-1:0]  ref_o,
  input logic [CP_W-1:0]   cp_o,
  input logic              byte_stb,
  input logic              stop_evt,
  input logic              read_end,
  input logic              por_q
);
  a_r4_div_commit_point: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(div_o) |-> $past(byte_stb || stop_evt));

  a_r5_ctrl_on_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable({mode_o, ref_o, cp_o}) |-> $past(byte_stb));

  a_r8_por_clear_on_read_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(por_q) |-> $past(read_end));

  a_r7_released_after_nack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    read_end |-> !sda_oe_o);

  a_r6_drive_only_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> !scl_i);
endmodule

bind tuner_i2c_regs tcr_chk #(
  .DIV_W(DIV_W), .MODE_W(MODE_W), .REF_W(REF_W), .CP_W(CP_W)
) u_chk (
  .clk_i, .rst_ni, .scl_i, .sda_oe_o, .div_o, .mode_o, .ref_o, .cp_o,
  .byte_stb, .stop_evt, .read_end, .por_q
);

// File: tb/tb_tuner_i2c_regs.sv
module tb_tuner_i2c_regs;
  localparam int CLK_P = 10;
  localparam int H     = 16;

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        scl = 1'b1, m_sda = 1'b1, lock = 1'b0;
  logic [1:0]  sel = 2'd0;
  logic        sda_oe;
  logic [14:0] div;
  logic [2:0]  mode, refs;
  logic [1:0]  cp;
  wire         sda_line = sda_oe ? 1'b0 : m_sda;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [14:0] e_div;
  logic [2:0]  e_mode, e_ref;
  logic [1:0]  e_cp;

  always #(CLK_P/2) clk = ~clk;

  tuner_i2c_regs dut (
    .clk_i(clk), .rst_ni, .scl_i(scl), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .addr_sel_i(sel), .lock_i(lock), .div_o(div), .mode_o(mode), .ref_o(refs), .cp_o(cp)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic i2c_start();
    m_sda = 1'b1; tick(H); scl = 1'b1; tick(H); m_sda = 1'b0; tick(H); scl = 1'b0; tick(H);
  endtask

  task automatic i2c_stop();
    m_sda = 1'b0; tick(H); scl = 1'b1; tick(H); m_sda = 1'b1; tick(H);
  endtask

  task automatic wr_byte(input logic [7:0] d, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = d[i]; tick(H); scl = 1'b1; tick(H); scl = 1'b0;
    end
    m_sda = 1'b1; tick(H); scl = 1'b1; tick(H/2); ack = (sda_line == 1'b0);
    tick(H/2); scl = 1'b0;
  endtask

  task automatic rd_byte(input logic m_ack, output logic [7:0] d);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(H); scl = 1'b1; tick(H/2); d[i] = sda_line; tick(H/2); scl = 1'b0;
    end
    m_sda = m_ack ? 1'b0 : 1'b1; tick(H); scl = 1'b1; tick(H); scl = 1'b0; tick(2);
    m_sda = 1'b1;
  endtask

  function automatic logic [7:0] addr_byte(input logic [1:0] a, input logic rd);
    return {5'b11000, a, rd};
  endfunction

  task automatic chk_regs(input string req);
    chk(req, div, e_div); chk(req, mode, e_mode); chk(req, refs, e_ref); chk(req, cp, e_cp);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; tick(5); rst_ni = 1'b1; tick(5);
    e_div = '0; e_mode = 3'b001; e_ref = '0; e_cp = '0;
  endtask

  initial begin
    logic       ack;
    logic [7:0] st;
    do_reset();
    // R9 reset state
    chk_regs("R9 reset"); chk("R9 sda released", sda_oe, 0);

    // R6/R8/R7 read path
    sel = 2'd2; lock = 1'b1; tick(10);
    i2c_start(); wr_byte(addr_byte(2'd2, 1), ack); chk("R1 read addr ack", ack, 1);
    rd_byte(1'b1, st); chk("R6 status por+lock", st, 8'hC0);
    rd_byte(1'b0, st); chk("R8 por kept across acked byte", st, 8'hC0);
    chk("R7 released after nack", sda_oe, 0);
    i2c_stop();
    lock = 1'b0; tick(10);
    i2c_start(); wr_byte(addr_byte(2'd2, 1), ack);
    rd_byte(1'b0, st); chk("R8 por cleared after read end", st, 8'h00);
    i2c_stop();
    lock = 1'b1; tick(10);
    i2c_start(); wr_byte(addr_byte(2'd2, 1), ack);
    rd_byte(1'b0, st); chk("R6 lock bit follows lock_i", st, 8'h40);
    i2c_stop();

    // R1 address sweep; mismatched transfers must not touch registers
    for (int s = 0; s < 4; s++) begin
      sel = 2'(s); tick(10);
      for (int a = 0; a < 4; a++) begin
        i2c_start(); wr_byte(addr_byte(2'(a), 0), ack);
        chk("R1 ack on match only", ack, (a == s));
        if (a != s) begin
          wr_byte(8'h05, ack); wr_byte(8'hAA, ack); wr_byte(8'hFE, ack);
        end
        i2c_stop();
        chk_regs("R1 foreign transfer ignored");
      end
    end

    // R2/R3/R4/R5 full write sweep
    sel = 2'd1; tick(10);
    for (int k = 0; k < 6; k++) begin
      logic [14:0] d, d2;
      logic [2:0]  m, r;
      logic [1:0]  c;
      d = 15'((k * 4951 + 64) & 32'h7fff);
      d2 = ~d;
      m = 3'((k + 2) % 8); r = 3'((k * 3) % 8); c = 2'(k % 4);
      i2c_start(); wr_byte(addr_byte(2'd1, 0), ack);
      wr_byte({1'b0, d[14:8]}, ack);
      chk("R4 div held until low byte", div, e_div);
      wr_byte(d[7:0], ack); e_div = d;
      chk("R4 div committed after low byte", div, e_div);
      wr_byte({1'b1, m, r, k[0]}, ack); e_mode = m; e_ref = r;
      chk("R5 mode before stop", mode, e_mode); chk("R2 ref from control byte", refs, e_ref);
      wr_byte({c, 6'b101010}, ack); e_cp = c;
      chk("R5 cp before stop", cp, e_cp);
      wr_byte({1'b0, d2[14:8]}, ack); wr_byte(d2[7:0], ack); e_div = d2;
      chk("R3 reclassified after current byte", div, e_div);
      i2c_stop();
      chk_regs("R3 after stop");
    end

    // R4 lone high byte commits at STOP
    i2c_start(); wr_byte(addr_byte(2'd1, 0), ack);
    wr_byte(8'h55, ack);
    chk("R4 lone high byte held", div, e_div);
    i2c_stop();
    e_div = {7'h55, e_div[7:0]};
    chk("R4 lone high byte at stop", div, e_div);

    // R2 control byte first
    i2c_start(); wr_byte(addr_byte(2'd1, 0), ack);
    wr_byte({1'b1, 3'b110, 3'b011, 1'b1}, ack); wr_byte({2'b10, 6'h3F}, ack);
    i2c_stop();
    e_mode = 3'b110; e_ref = 3'b011; e_cp = 2'b10;
    chk_regs("R2 control byte first");

    // R8 writes do not clear por; R9 reset again
    do_reset();
    chk_regs("R9 second reset");
    i2c_start(); wr_byte(addr_byte(2'd1, 0), ack); wr_byte(8'h12, ack); wr_byte(8'h34, ack);
    i2c_stop(); e_div = 15'h1234;
    chk("R2 divider pair after reset", div, e_div);
    i2c_start(); wr_byte(addr_byte(2'd1, 1), ack);
    rd_byte(1'b0, st); chk("R8 por survives write", st, 8'hC0);
    i2c_stop();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule